// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port with Edge Interrupts

This block gives software control over sixteen chip pins through a small register file reached over a simple word-wide bus. Each pin is set to drive or to sense. Sensed pins pass through two synchronizing flip-flops. Software reads them through a per-pin enable that forces disabled pins to read as zero.

Each sensing pin can raise an interrupt on one edge, chosen per pin as rising or falling. A per-pin mask blocks the event. Events that get through are held in a status register, and software clears it by writing ones. A single interrupt line stays high while any status bit is set.

The bus accepts only 16-bit accesses. Any other width is refused: a refused write changes nothing and a refused read returns zero. Unmapped offsets read as zero and ignore writes.

Top module: `gpe_port`

## Requirements
- R1: After reset, the registers read as follows: input data 0x0000, output data 0xFFFF, direction 0xFFFF, edge select 0xFFFF, mask 0xFFFF, status 0x0000 and pin enable 0xFFFF. The interrupt output is low and no pin is driven.
- R2: A read of offset 0x00 returns the synchronized pin levels ANDed with the pin-enable register at offset 0x18. A write to offset 0x00 has no effect.
- R3: A direction bit (offset 0x08) of 0 makes the pin an output. Its `pin_oe` bit is then 1 and its `pin_out` bit equals the output-data bit (offset 0x04). A direction bit of 1 makes the pin an input, with `pin_oe` 0 and `pin_out` 0.
- R4: An edge-select bit (offset 0x0C) of 1 latches an event on a 0-to-1 transition of the synchronized pin. A value of 0 latches an event on a 1-to-0 transition. The other transition sets nothing.
- R5: An event sets its status bit (offset 0x14) only when the pin's direction bit is 1 and its mask bit (offset 0x10) is 0. A masked or output pin never sets its status bit, including later when it is unmasked.
- R6: Writing to the status register clears each bit written as 1 and leaves the other bits unchanged. The `irq` output is high exactly while any status bit is 1.
- R7: If a status clear and a new event hit the same bit in the same cycle, that bit stays set.
- R8: The bus size code 1 means a 16-bit access. An access with any other size code changes no register, and a read with such a code returns 0.
- R9: A read of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18 returns 0, and a write to such an offset changes no register.
- R10: A pin change shows at offset 0x00 two clock edges after it is sampled. The resulting status bit and `irq` follow one edge later.
- R11: Offsets 0x04, 0x08, 0x0C, 0x10 and 0x18 read back the last value written to them with a valid access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access width code; 1 = 16-bit, all others refused |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data, valid in the cycle of the read |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Level driven on output pins |
| pin_oe | output | NPINS | 1 where the pin is driven |
| irq | output | 1 | High while any status bit is set |

## Verification
The hardest case to reach from the ports is a status clear and a fresh event on the same bit in the same clock edge. The edge only becomes visible two synchronizer stages after the pin moves, so the bench first latches the bit. It then releases and raises the pin again, and times a write to the status register so that the write lands on the exact edge where the second rising transition is detected. A second bit, already pending, is cleared by the same write, which confirms that the clear itself took effect. Each pin is also swept through both edge polarities, with the wrong-polarity transition checked to leave the status at zero.

// File: rtl/gpe_pkg.sv
// gpe_pkg: shared definitions for the GPIO edge port.
// Holds the register selector type, the access-size code and the
// offset decoder. Assumes byte offsets with 4-byte register spacing.
package gpe_pkg;

    // Access width code carried on bus_size
    localparam logic [1:0] ACC_HALF = 2'd1;

    // Byte offsets of the registers
    localparam logic [7:0] OFS_DIN  = 8'h00;
    localparam logic [7:0] OFS_DOUT = 8'h04;
    localparam logic [7:0] OFS_DIR  = 8'h08;
    localparam logic [7:0] OFS_ESEL = 8'h0C;
    localparam logic [7:0] OFS_MASK = 8'h10;
    localparam logic [7:0] OFS_STAT = 8'h14;
    localparam logic [7:0] OFS_PEN  = 8'h18;

    typedef enum logic [2:0] {
        SEL_DIN,
        SEL_DOUT,
        SEL_DIR,
        SEL_ESEL,
        SEL_MASK,
        SEL_STAT,
        SEL_PEN,
        SEL_NONE
    } reg_sel_e;

    // Map a low address byte onto a register selector
    function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
        case (ofs)
            OFS_DIN:  return SEL_DIN;
            OFS_DOUT: return SEL_DOUT;
            OFS_DIR:  return SEL_DIR;
            OFS_ESEL: return SEL_ESEL;
            OFS_MASK: return SEL_MASK;
            OFS_STAT: return SEL_STAT;
            OFS_PEN:  return SEL_PEN;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpe_sync.sv
// gpe_sync: two-flop synchronizer per pin plus a history flop.
// Produces the synchronized level and one-cycle rise/fall pulses.
// Assumes pin_in is asynchronous to clk; all flops reset to 0.
module gpe_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] st1;
    logic [W-1:0] st2;
    logic [W-1:0] hist;

    for (genvar b = 0; b < W; b++) begin : g_bit
        // Two-stage capture of the pin, then one cycle of history
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st1[b]  <= 1'b0;
                st2[b]  <= 1'b0;
                hist[b] <= 1'b0;
            end else begin
                st1[b]  <= pin_in[b];
                st2[b]  <= st1[b];
                hist[b] <= st2[b];
            end
        end
    end

    // Transition pulses from current versus previous synchronized level
    always_comb begin
        lvl  = st2;
        rise = st2 & ~hist;
        fall = ~st2 & hist;
    end

    // Cycles since reset, saturating, used only by the check below
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)             warm <= 2'd0;
        else if (warm != 2'd3)  warm <= warm + 2'd1;
    end

    // R10
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (lvl == $past(pin_in, 2)));

endmodule

// File: rtl/gpe_regs.sv
// gpe_regs: bus decode and the control register file.
// Accepts only 16-bit accesses (size code 1) to exact offsets; reads
// are combinational in the access cycle. The status register lives in
// gpe_irq; this block only forwards the write-one-to-clear request.
module gpe_regs #(
    parameter int W  = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [1:0]    bus_size,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  din,
    input  logic [W-1:0]  status,
    output logic [W-1:0]  out_q,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  esel_q,
    output logic [W-1:0]  mask_q,
    output logic [W-1:0]  pen_q,
    output logic          clr_en,
    output logic [W-1:0]  clr_bits
);
    import gpe_pkg::*;

    localparam int HI_BITS = AW - 8;

    logic     acc_ok;
    logic     wr_ok;
    logic     rd_ok;
    logic     hi_zero;
    reg_sel_e sel;

    // Qualify the access and decode the target register
    always_comb begin
        acc_ok  = bus_sel && (bus_size == ACC_HALF);
        wr_ok   = acc_ok && bus_wr;
        rd_ok   = acc_ok && !bus_wr;
        hi_zero = ((bus_addr >> 8) == '0);
        sel     = hi_zero ? decode_ofs(bus_addr[7:0]) : SEL_NONE;
    end

    // Control registers, written only by accepted accesses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '1;
            dir_q  <= '1;
            esel_q <= '1;
            mask_q <= '1;
            pen_q  <= '1;
        end else if (wr_ok) begin
            case (sel)
                SEL_DOUT: out_q  <= bus_wdata;
                SEL_DIR:  dir_q  <= bus_wdata;
                SEL_ESEL: esel_q <= bus_wdata;
                SEL_MASK: mask_q <= bus_wdata;
                SEL_PEN:  pen_q  <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // Write-one-to-clear request toward the status register
    always_comb begin
        clr_en   = wr_ok && (sel == SEL_STAT);
        clr_bits = bus_wdata;
    end

    // Read multiplexer; refused or unmapped reads give zero
    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            case (sel)
                SEL_DIN:  bus_rdata = din & pen_q;
                SEL_DOUT: bus_rdata = out_q;
                SEL_DIR:  bus_rdata = dir_q;
                SEL_ESEL: bus_rdata = esel_q;
                SEL_MASK: bus_rdata = mask_q;
                SEL_STAT: bus_rdata = status;
                SEL_PEN:  bus_rdata = pen_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R8
    bad_size_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && (bus_size != ACC_HALF)) |=>
        ($stable(out_q) && $stable(dir_q) && $stable(esel_q) &&
         $stable(mask_q) && $stable(pen_q)));

    // R9
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && (sel == SEL_NONE)) |=>
        ($stable(out_q) && $stable(dir_q) && $stable(esel_q) &&
         $stable(mask_q) && $stable(pen_q)));

    // R8
    bad_size_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_size != ACC_HALF)) |-> (bus_rdata == '0));

    if (HI_BITS > 0) begin : g_wide_addr
        // R9
        high_addr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && !hi_zero) |-> (bus_rdata == '0));
    end

endmodule

// File: rtl/gpe_irq.sv
// gpe_irq: event qualification, sticky status and the interrupt line.
// Assumes rise/fall are single-cycle pulses from gpe_sync. A new event
// overrides a same-cycle clear of the same bit.
module gpe_irq #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] esel_q,
    input  logic [W-1:0] mask_q,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] status,
    output logic         irq
);
    logic [W-1:0] hit;
    logic [W-1:0] keep;

    // Events that pass polarity, direction and mask
    always_comb begin
        hit  = dir_q & ~mask_q & ((esel_q & rise) | (~esel_q & fall));
        keep = clr_en ? (status & ~clr_bits) : status;
    end

    // Sticky status: clear first, then OR in new events
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= keep | hit;
    end

    // Interrupt line follows any pending bit
    always_comb irq = |status;

    // R4 R7
    event_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rise | fall)) |=>
        ((status & $past(dir_q & ~mask_q & ((esel_q & rise) | (~esel_q & fall))))
         == $past(dir_q & ~mask_q & ((esel_q & rise) | (~esel_q & fall)))));

    // R5
    no_stray_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(dir_q & ~mask_q & (rise | fall))) == '0));

    // R6
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(clr_en));

    // R6
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_en && !(|(rise | fall))) |=> $stable(status));

endmodule

// File: rtl/gpe_port.sv
// gpe_port: top of the GPIO edge port.
// Wires the synchronizer, register file and interrupt logic, and forms
// the pad controls: a direction bit of 0 drives the output-data bit.
// Assumes a single clock and synchronous active-low reset.
module gpe_port #(
    parameter int NPINS  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    logic [NPINS-1:0] lvl;
    logic [NPINS-1:0] rise;
    logic [NPINS-1:0] fall;
    logic [NPINS-1:0] status;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] esel_q;
    logic [NPINS-1:0] mask_q;
    logic [NPINS-1:0] pen_q;
    logic             clr_en;
    logic [NPINS-1:0] clr_bits;

    gpe_sync #(.W(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .lvl    (lvl),
        .rise   (rise),
        .fall   (fall)
    );

    gpe_regs #(.W(NPINS), .AW(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_size  (bus_size),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .din       (lvl),
        .status    (status),
        .out_q     (out_q),
        .dir_q     (dir_q),
        .esel_q    (esel_q),
        .mask_q    (mask_q),
        .pen_q     (pen_q),
        .clr_en    (clr_en),
        .clr_bits  (clr_bits)
    );

    gpe_irq #(.W(NPINS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .fall     (fall),
        .dir_q    (dir_q),
        .esel_q   (esel_q),
        .mask_q   (mask_q),
        .clr_en   (clr_en),
        .clr_bits (clr_bits),
        .status   (status),
        .irq      (irq)
    );

    // Pad controls: drive only where the direction bit is 0
    always_comb begin
        pin_oe  = ~dir_q;
        pin_out = out_q & ~dir_q;
    end

    // R3
    input_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0));

endmodule

// File: tb/test_gpe_port.sv
// Self-checking bench for gpe_port: register sweep, per-pin edge sweep
// in both polarities, qualification, collision and refused accesses.
module test_gpe_port;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_DIN  = 8'h00;
    localparam logic [7:0] A_DOUT = 8'h04;
    localparam logic [7:0] A_DIR  = 8'h08;
    localparam logic [7:0] A_ESEL = 8'h0C;
    localparam logic [7:0] A_MASK = 8'h10;
    localparam logic [7:0] A_STAT = 8'h14;
    localparam logic [7:0] A_PEN  = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_size = 2'd1;
    logic [7:0]  bus_addr = 8'h00;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = 16'h0000;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    gpe_port i_gpe_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_size  (bus_size),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%04h exp=%04h", tag, act, exp);
        end
    endtask

    task automatic wr_sz(input logic [7:0] a, input logic [15:0] d, input logic [1:0] sz);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_size = 2'd1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        wr_sz(a, d, 2'd1);
    endtask

    task automatic rd_sz(input logic [7:0] a, input logic [1:0] sz, output logic [15:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
        #1;
        v = bus_rdata;
        bus_sel = 1'b0; bus_size = 2'd1;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [15:0] exp, input string tag);
        logic [15:0] v;
        rd_sz(a, 2'd1, v);
        chk(v === exp, tag, v, exp);
    endtask

    task automatic settle(input logic [15:0] v);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    // Watchdog: counts as a failed check and still reports
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(A_DIN,  16'h0000, "R1 din");
        rd_chk(A_DOUT, 16'hFFFF, "R1 dout");
        rd_chk(A_DIR,  16'hFFFF, "R1 dir");
        rd_chk(A_ESEL, 16'hFFFF, "R1 esel");
        rd_chk(A_MASK, 16'hFFFF, "R1 mask");
        rd_chk(A_STAT, 16'h0000, "R1 stat");
        rd_chk(A_PEN,  16'hFFFF, "R1 pen");
        chk(irq === 1'b0, "R1 irq", {15'd0, irq}, 16'h0000);
        chk(pin_oe === 16'h0000, "R1 pin_oe", pin_oe, 16'h0000);

        // R11 readback over several patterns
        foreach (A_PAT[k]) begin end
        for (int k = 0; k < 4; k++) begin
            logic [15:0] p;
            p = 16'hA5C3 ^ (16'h1111 * k[15:0]) ^ {k[7:0], 8'h0F};
            wr(A_DOUT, p);        rd_chk(A_DOUT, p, "R11 dout");
            wr(A_DIR, ~p);        rd_chk(A_DIR, ~p, "R11 dir");
            wr(A_ESEL, p ^ 16'hFF00); rd_chk(A_ESEL, p ^ 16'hFF00, "R11 esel");
            wr(A_MASK, {p[7:0], p[15:8]}); rd_chk(A_MASK, {p[7:0], p[15:8]}, "R11 mask");
            wr(A_PEN, p | 16'h0101); rd_chk(A_PEN, p | 16'h0101, "R11 pen");
        end

        // R3 pad controls for several direction patterns
        for (int k = 0; k < 4; k++) begin
            logic [15:0] d, o;
            d = 16'hF0F0 >> k;
            o = 16'h1234 + 16'h1111 * k[15:0];
            wr(A_DIR, d);
            wr(A_DOUT, o);
            @(negedge clk);
            chk(pin_oe === ~d, "R3 pin_oe", pin_oe, ~d);
            chk(pin_out === (o & ~d), "R3 pin_out", pin_out, o & ~d);
        end

        // Input configuration for the remaining tests
        wr(A_DIR, 16'hFFFF);
        wr(A_MASK, 16'hFFFF);

        // R2 pin-enable qualification and write ignored
        wr(A_PEN, 16'h0FF0);
        settle(16'hABCD);
        rd_chk(A_DIN, 16'hABCD & 16'h0FF0, "R2 din qualified");
        wr(A_DIN, 16'h5555);
        rd_chk(A_DIN, 16'hABCD & 16'h0FF0, "R2 din write ignored");
        wr(A_PEN, 16'hFFFF);
        settle(16'h3C96);
        rd_chk(A_DIN, 16'h3C96, "R2 din full enable");

        // R10 synchronizer latency
        @(negedge clk);
        pin_in = 16'h8001;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_DIN; #1;
        chk(bus_rdata === 16'h3C96, "R10 one edge old", bus_rdata, 16'h3C96);
        @(negedge clk); #1;
        chk(bus_rdata === 16'h8001, "R10 two edges new", bus_rdata, 16'h8001);
        bus_sel = 1'b0;

        // R4 R6 per-pin edge sweep
        wr(A_MASK, 16'h0000);
        for (int i = 0; i < 16; i++) begin
            logic [15:0] b;
            b = 16'h0001 << i;
            wr(A_ESEL, 16'hFFFF);
            settle(16'h0000);
            wr(A_STAT, 16'hFFFF);
            settle(b);
            rd_chk(A_STAT, b, "R4 rising sets");
            chk(irq === 1'b1, "R6 irq high", {15'd0, irq}, 16'h0001);
            wr(A_STAT, b);
            rd_chk(A_STAT, 16'h0000, "R6 clear");
            chk(irq === 1'b0, "R6 irq low", {15'd0, irq}, 16'h0000);
            settle(16'h0000);
            rd_chk(A_STAT, 16'h0000, "R4 falling ignored when rising");
            wr(A_ESEL, 16'h0000);
            settle(16'hFFFF);
            rd_chk(A_STAT, 16'h0000, "R4 rising ignored when falling");
            settle(~b);
            rd_chk(A_STAT, b, "R4 falling sets");
        end

        // R10 status latency: pin sampled, status visible after third edge
        wr(A_ESEL, 16'hFFFF);
        settle(16'h0000);
        wr(A_STAT, 16'hFFFF);
        @(negedge clk);
        pin_in = 16'h0040;
        repeat (2) @(negedge clk);
        chk(irq === 1'b0, "R10 irq not yet", {15'd0, irq}, 16'h0000);
        @(negedge clk);
        chk(irq === 1'b1, "R10 irq third edge", {15'd0, irq}, 16'h0001);
        settle(16'h0000);
        wr(A_STAT, 16'hFFFF);

        // R5 mask and direction block events
        wr(A_MASK, 16'h0008);
        wr(A_DIR, 16'hFFDF);
        settle(16'h0028);
        rd_chk(A_STAT, 16'h0000, "R5 masked/output pin");
        chk(irq === 1'b0, "R5 irq stays low", {15'd0, irq}, 16'h0000);
        wr(A_MASK, 16'h0000);
        wr(A_DIR, 16'hFFFF);
        rd_chk(A_STAT, 16'h0000, "R5 no late set");
        settle(16'h0000);

        // R7 clear collides with new event on the same bit
        wr(A_STAT, 16'hFFFF);
        settle(16'h0210);
        rd_chk(A_STAT, 16'h0210, "R7 setup");
        settle(16'h0200);
        @(negedge clk);
        pin_in = 16'h0210;
        @(negedge clk);
        wr(A_STAT, 16'h0210);
        rd_chk(A_STAT, 16'h0010, "R7 event wins");
        chk(irq === 1'b1, "R7 irq held", {15'd0, irq}, 16'h0001);

        // R8 refused widths
        wr(A_DOUT, 16'h1357);
        for (int s = 0; s < 4; s++) begin
            if (s != 1) begin
                wr_sz(A_DOUT, 16'hECA8, s[1:0]);
                wr_sz(A_STAT, 16'hFFFF, s[1:0]);
                rd_sz(A_DOUT, s[1:0], v);
                chk(v === 16'h0000, "R8 bad read zero", v, 16'h0000);
            end
        end
        rd_chk(A_DOUT, 16'h1357, "R8 dout kept");
        rd_chk(A_STAT, 16'h0010, "R8 status kept");

        // R9 unmapped offsets
        for (int k = 0; k < 4; k++) begin
            logic [7:0] ua;
            ua = (k == 0) ? 8'h1C : (k == 1) ? 8'h02 : (k == 2) ? 8'h40 : 8'hFC;
            wr(ua, 16'h0000);
            rd_chk(ua, 16'h0000, "R9 unmapped read");
        end
        rd_chk(A_DOUT, 16'h1357, "R9 dout kept");
        rd_chk(A_DIR,  16'hFFFF, "R9 dir kept");
        rd_chk(A_ESEL, 16'hFFFF, "R9 esel kept");
        rd_chk(A_MASK, 16'h0000, "R9 mask kept");
        rd_chk(A_PEN,  16'hFFFF, "R9 pen kept");
        rd_chk(A_STAT, 16'h0010, "R9 status kept");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    localparam int A_PAT [1] = '{0};
endmodule